// File: doc/BRIEF.md
# Interrupt Request Priority Arbiter

This block holds the three 256-entry state vectors of a per-processor interrupt controller: the vectors still waiting (pending), the vectors the processor is handling (in service), and whether each vector arrived as a level or an edge. Vector requests arrive already routed to this processor. The block decides whether to raise an interrupt line toward the processor core, and it supplies the vector number the core receives when it acknowledges.

Priority follows the vector number, so a higher number wins. The upper four bits of a vector form its priority class. A processor priority is formed from the task priority and the highest vector in service. A pending vector is signalled only when its class is above that priority. An acknowledge that the task priority blocks, or that finds nothing pending, returns a programmable spurious vector and leaves the state alone. An end-of-interrupt strobe retires the highest vector in service, and lower-class requests may then reach the processor.

The block has a 9-bit spurious-vector register. Its top bit is the software enable, and its low byte is the spurious vector. A task-priority class is written through a separate 4-bit port.

Top module: `intr_prio_arbiter`

## Requirements
- R1: After reset, irqPending is 0, eoiLevel is 0, the task priority is 0 and the spurious register holds 0x0FF with its enable bit (bit 8) clear, so ackVector reads 0xFF and a request raises no interrupt.
- R2: A request (reqValid) sets pending bit reqVector. It also writes reqLevel into that vector's trigger bit: 1 marks level and 0 marks edge, and a later edge request clears an earlier level mark.
- R3: While spurious-register bit 8 is 0, irqPending stays 0 and an acknowledge returns bits 7:0 of the spurious register without changing the pending or in-service state.
- R4: The search picks the highest-numbered set bit across all eight 32-bit words, including vector 0x00, vector 0xFF and the boundary between words.
- R5: The processor priority equals the task priority when no vector is in service or when the task class (bits 7:4) is at least the top in-service class. Otherwise it equals the top in-service class followed by four zero bits. irqPending is 1 only when the block is enabled, a request is pending, and either the processor priority is 0 or the top request's bits 7:4 are greater than the processor priority's bits 7:4.
- R6: When the task priority is nonzero and the top pending vector is less than or equal to it, ackVector returns the spurious byte and an acknowledge changes no state.
- R7: Otherwise an acknowledge returns the top pending vector on ackVector, clears its pending bit and sets its in-service bit. This grant does not depend on the in-service priority.
- R8: An end-of-interrupt clears the highest in-service bit, and irqPending is re-evaluated from the cycle that follows. With nothing in service it has no effect.
- R9: A spurious-register write stores all 9 bits of svrData: bit 8 is the enable and bits 7:0 are the spurious vector.
- R10: A task-priority write stores tprClass in bits 7:4 of the task priority and zeros in bits 3:0.
- R11: With nothing pending, ackVector is the spurious byte, irqPending is 0, and an acknowledge changes no state.
- R12: eoiLevel shows the trigger bit of the highest in-service vector (1 = level), and is 0 when nothing is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | A routed vector request this cycle |
| reqVector | input | 8 | Requested vector number |
| reqLevel | input | 1 | Trigger of the request, 1 = level, 0 = edge |
| ackStrobe | input | 1 | Processor acknowledge |
| eoiStrobe | input | 1 | End-of-interrupt |
| tprWrite | input | 1 | Task-priority class write |
| tprClass | input | 4 | Task-priority class, stored in bits 7:4 |
| svrWrite | input | 1 | Spurious-register write |
| svrData | input | 9 | Spurious-register value, bit 8 = enable |
| irqPending | output | 1 | Interrupt signalled to the processor |
| ackVector | output | 8 | Vector an acknowledge in this cycle returns |
| eoiLevel | output | 1 | Trigger bit of the vector an end-of-interrupt would retire |

## Verification
A stimulus table walks through the following patterns:
- nested grants of rising class, which show that the in-service priority masks irqPending but does not stop an acknowledge;
- task-priority classes just below and just above the top request, which separate the class test used for signalling from the full-vector test used by acknowledge;
- repeated requests to one vector with different triggers, which show that the last trigger written wins;
- vectors 0x00 and 0xFF, and acknowledges while the block is disabled, which show that blocked acknowledges leave no trace once the block is enabled again.

Directed tests then cover reset values, the boundary between two words, and a request of equal class, which must not be signalled.

// File: rtl/intr_arb_pkg.sv
package intr_arb_pkg;
  // width of a priority class (upper bits of a vector number)
  localparam int CLS_W = 4;

  // strobes from the control decision into the state datapath
  typedef struct packed {
    logic grant;   // move top pending vector into service
    logic retire;  // clear top in-service vector
  } arbStrobe_t;
endpackage

// File: rtl/intr_arb_hiscan.sv
module intr_arb_hiscan #(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32
) (
  input  logic [NUM_VEC-1:0]         bits,
  output logic                       found,
  output logic [$clog2(NUM_VEC)-1:0] idx
);
  localparam int NUM_WORDS = NUM_VEC / WORD_W;
  localparam int VEC_W     = $clog2(NUM_VEC);
  localparam int BIT_W     = $clog2(WORD_W);
  localparam int WSEL_W    = VEC_W - BIT_W;

  logic [NUM_WORDS-1:0]       wordHit;
  logic [NUM_WORDS*BIT_W-1:0] wordPosFlat;

  // first level: highest set bit inside each word
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [BIT_W-1:0] pos;
    assign wordHit[w] = |bits[w*WORD_W +: WORD_W];
    always_comb begin
      pos = '0;
      for (int b = 0; b < WORD_W; b++) begin
        if (bits[w*WORD_W + b]) pos = BIT_W'(b);
      end
    end
    assign wordPosFlat[w*BIT_W +: BIT_W] = pos;
  end

  // second level: highest word that has any bit set
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (wordHit[w]) begin
        found = 1'b1;
        idx   = {WSEL_W'(w), wordPosFlat[w*BIT_W +: BIT_W]};
      end
    end
  end
endmodule

// File: rtl/intr_arb_datapath.sv
module intr_arb_datapath
  import intr_arb_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic [VEC_W-1:0] reqVector,
  input  logic             reqLevel,
  input  logic             tprWrite,
  input  logic [CLS_W-1:0] tprClass,
  input  logic             svrWrite,
  input  logic [VEC_W:0]   svrData,
  input  arbStrobe_t       strb,
  output logic             irrAny,
  output logic [VEC_W-1:0] irrTop,
  output logic             isrAny,
  output logic [VEC_W-1:0] isrTop,
  output logic [VEC_W-1:0] tprQ,
  output logic [VEC_W:0]   svrQ,
  output logic             eoiLevel
);
  logic [NUM_VEC-1:0] irrQ, isrQ, tmrQ;
  logic [NUM_VEC-1:0] irrN, isrN, tmrN;

  intr_arb_hiscan #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_irrScan (
    .bits(irrQ), .found(irrAny), .idx(irrTop));
  intr_arb_hiscan #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_isrScan (
    .bits(isrQ), .found(isrAny), .idx(isrTop));

  // next state: a grant clears before an incoming request sets, so a
  // request for the granted vector in the same cycle stays pending
  always_comb begin
    irrN = irrQ;
    isrN = isrQ;
    tmrN = tmrQ;
    if (strb.grant)  irrN[irrTop] = 1'b0;
    if (reqValid)    irrN[reqVector] = 1'b1;
    if (strb.retire) isrN[isrTop] = 1'b0;
    if (strb.grant)  isrN[irrTop] = 1'b1;
    if (reqValid)    tmrN[reqVector] = reqLevel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irrQ <= '0;
      isrQ <= '0;
      tmrQ <= '0;
      tprQ <= '0;
      svrQ <= {1'b0, {VEC_W{1'b1}}};
    end else begin
      irrQ <= irrN;
      isrQ <= isrN;
      tmrQ <= tmrN;
      if (tprWrite) tprQ <= {tprClass, {(VEC_W-CLS_W){1'b0}}};
      if (svrWrite) svrQ <= svrData;
    end
  end

  assign eoiLevel = isrAny & tmrQ[isrTop];

  AST_TRIG_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> tmrQ[$past(reqVector)] == $past(reqLevel)); // R2
  AST_GRANT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    strb.grant && !reqValid |=> isrQ[$past(irrTop)] && !irrQ[$past(irrTop)]); // R7
  AST_RETIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    strb.retire && !strb.grant |=> !isrQ[$past(isrTop)]); // R8
  AST_ISR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.grant && !strb.retire |=> $stable(isrQ)); // R6
  AST_SVR_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    svrWrite |=> svrQ == $past(svrData)); // R9
endmodule

// File: rtl/intr_arb_control.sv
module intr_arb_control
  import intr_arb_pkg::*;
#(
  parameter int NUM_VEC = 256,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ackStrobe,
  input  logic             eoiStrobe,
  input  logic             irrAny,
  input  logic [VEC_W-1:0] irrTop,
  input  logic             isrAny,
  input  logic [VEC_W-1:0] isrTop,
  input  logic [VEC_W-1:0] tprQ,
  input  logic [VEC_W:0]   svrQ,
  output arbStrobe_t       strb,
  output logic             irqPending,
  output logic [VEC_W-1:0] ackVector
);
  logic             swEnable;
  logic [CLS_W-1:0] tprCls, isrCls, irrCls, pprCls;
  logic [VEC_W-1:0] pprVal;
  logic             tprBlocks, grantable;

  assign swEnable = svrQ[VEC_W];
  assign tprCls   = tprQ[VEC_W-1 -: CLS_W];
  assign isrCls   = isrTop[VEC_W-1 -: CLS_W];
  assign irrCls   = irrTop[VEC_W-1 -: CLS_W];

  // processor priority from task priority and top in-service class
  always_comb begin
    if (!isrAny || tprCls >= isrCls) pprVal = tprQ;
    else                             pprVal = {isrCls, {(VEC_W-CLS_W){1'b0}}};
  end
  assign pprCls = pprVal[VEC_W-1 -: CLS_W];

  assign irqPending = swEnable && irrAny && ((pprVal == '0) || (irrCls > pprCls));

  // acknowledge uses the full vector against the task priority
  assign tprBlocks = (tprQ != '0) && (irrTop <= tprQ);
  assign grantable = swEnable && irrAny && !tprBlocks;
  assign ackVector = grantable ? irrTop : svrQ[VEC_W-1:0];

  assign strb.grant  = ackStrobe && grantable;
  assign strb.retire = eoiStrobe && isrAny;

  AST_PEND_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irqPending |-> swEnable && irrAny); // R3
  AST_NO_GRANT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !swEnable |-> !strb.grant); // R3
  AST_PEND_ABOVE_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    irqPending && isrAny |-> irrCls > isrCls || tprCls >= isrCls); // R5
endmodule

// File: rtl/intr_prio_arbiter.sv
module intr_prio_arbiter
  import intr_arb_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic [VEC_W-1:0] reqVector,
  input  logic             reqLevel,
  input  logic             ackStrobe,
  input  logic             eoiStrobe,
  input  logic             tprWrite,
  input  logic [CLS_W-1:0] tprClass,
  input  logic             svrWrite,
  input  logic [VEC_W:0]   svrData,
  output logic             irqPending,
  output logic [VEC_W-1:0] ackVector,
  output logic             eoiLevel
);
  arbStrobe_t       strb;
  logic             irrAny, isrAny;
  logic [VEC_W-1:0] irrTop, isrTop, tprQ;
  logic [VEC_W:0]   svrQ;

  intr_arb_datapath #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqVector(reqVector), .reqLevel(reqLevel),
    .tprWrite(tprWrite), .tprClass(tprClass),
    .svrWrite(svrWrite), .svrData(svrData),
    .strb(strb),
    .irrAny(irrAny), .irrTop(irrTop), .isrAny(isrAny), .isrTop(isrTop),
    .tprQ(tprQ), .svrQ(svrQ), .eoiLevel(eoiLevel));

  intr_arb_control #(.NUM_VEC(NUM_VEC)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .ackStrobe(ackStrobe), .eoiStrobe(eoiStrobe),
    .irrAny(irrAny), .irrTop(irrTop), .isrAny(isrAny), .isrTop(isrTop),
    .tprQ(tprQ), .svrQ(svrQ),
    .strb(strb), .irqPending(irqPending), .ackVector(ackVector));
endmodule

// File: tb/sim_intr_prio_arbiter.sv
`timescale 1ns/1ps
module sim_intr_prio_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reqValid = 1'b0, reqLevel = 1'b0, ackStrobe = 1'b0, eoiStrobe = 1'b0;
  logic [7:0] reqVector = '0;
  logic       tprWrite = 1'b0, svrWrite = 1'b0;
  logic [3:0] tprClass = '0;
  logic [8:0] svrData = '0;
  logic       irqPending, eoiLevel;
  logic [7:0] ackVector;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  intr_prio_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqVector(reqVector),
    .reqLevel(reqLevel), .ackStrobe(ackStrobe), .eoiStrobe(eoiStrobe),
    .tprWrite(tprWrite), .tprClass(tprClass), .svrWrite(svrWrite),
    .svrData(svrData), .irqPending(irqPending), .ackVector(ackVector),
    .eoiLevel(eoiLevel));

  localparam logic [2:0] OP_REQ = 3'd1, OP_ACK = 3'd2, OP_EOI = 3'd3,
                         OP_TPR = 3'd4, OP_SVR = 3'd5;
  // row: op[22:20] arg[19:11] lvl[10] expPend[9] expVec[8:1] expLvl[0]
  localparam int NROWS = 31;
  localparam logic [22:0] STIM [NROWS] = '{
    {OP_SVR, 9'h1E7, 1'b0, 1'b0, 8'hE7, 1'b0}, // R9 enable
    {OP_REQ, 9'h031, 1'b0, 1'b1, 8'h31, 1'b0}, // R2
    {OP_REQ, 9'h085, 1'b1, 1'b1, 8'h85, 1'b0}, // R4
    {OP_REQ, 9'h052, 1'b0, 1'b1, 8'h85, 1'b0},
    {OP_ACK, 9'h000, 1'b0, 1'b0, 8'h52, 1'b1}, // R7 R5 R12
    {OP_REQ, 9'h09A, 1'b0, 1'b1, 8'h9A, 1'b1}, // R5 higher class
    {OP_ACK, 9'h000, 1'b0, 1'b0, 8'h52, 1'b0},
    {OP_EOI, 9'h000, 1'b0, 1'b0, 8'h52, 1'b1}, // R8
    {OP_EOI, 9'h000, 1'b0, 1'b1, 8'h52, 1'b0}, // R8
    {OP_TPR, 9'h005, 1'b0, 1'b0, 8'h52, 1'b0}, // R10 class vs full vector
    {OP_TPR, 9'h006, 1'b0, 1'b0, 8'hE7, 1'b0}, // R6
    {OP_ACK, 9'h000, 1'b0, 1'b0, 8'hE7, 1'b0}, // R6 no change
    {OP_REQ, 9'h075, 1'b1, 1'b1, 8'h75, 1'b0},
    {OP_REQ, 9'h075, 1'b0, 1'b1, 8'h75, 1'b0}, // R2 edge clears level
    {OP_ACK, 9'h000, 1'b0, 1'b0, 8'hE7, 1'b0}, // R12
    {OP_TPR, 9'h000, 1'b0, 1'b0, 8'h52, 1'b0},
    {OP_EOI, 9'h000, 1'b0, 1'b1, 8'h52, 1'b0},
    {OP_ACK, 9'h000, 1'b0, 1'b0, 8'h31, 1'b0},
    {OP_ACK, 9'h000, 1'b0, 1'b0, 8'hE7, 1'b0}, // R7 grant despite isr
    {OP_ACK, 9'h000, 1'b0, 1'b0, 8'hE7, 1'b0}, // R11
    {OP_EOI, 9'h000, 1'b0, 1'b0, 8'hE7, 1'b0},
    {OP_EOI, 9'h000, 1'b0, 1'b0, 8'hE7, 1'b0},
    {OP_EOI, 9'h000, 1'b0, 1'b0, 8'hE7, 1'b0}, // R8 empty
    {OP_REQ, 9'h0FF, 1'b1, 1'b1, 8'hFF, 1'b0}, // R4 top vector
    {OP_REQ, 9'h000, 1'b0, 1'b1, 8'hFF, 1'b0},
    {OP_ACK, 9'h000, 1'b0, 1'b0, 8'h00, 1'b1}, // R4 vector zero
    {OP_SVR, 9'h0E7, 1'b0, 1'b0, 8'hE7, 1'b1}, // R3 disable
    {OP_ACK, 9'h000, 1'b0, 1'b0, 8'hE7, 1'b1}, // R3
    {OP_SVR, 9'h1C3, 1'b0, 1'b0, 8'h00, 1'b1}, // R3 R9 nothing moved
    {OP_EOI, 9'h000, 1'b0, 1'b1, 8'h00, 1'b0},
    {OP_ACK, 9'h000, 1'b0, 1'b0, 8'hC3, 1'b0}  // R11
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic doOp(input logic [2:0] op, input logic [8:0] arg, input logic lvl);
    @(negedge clk);
    case (op)
      OP_REQ: begin reqValid = 1'b1; reqVector = arg[7:0]; reqLevel = lvl; end
      OP_ACK: ackStrobe = 1'b1;
      OP_EOI: eoiStrobe = 1'b1;
      OP_TPR: begin tprWrite = 1'b1; tprClass = arg[3:0]; end
      OP_SVR: begin svrWrite = 1'b1; svrData = arg; end
      default: ;
    endcase
    @(negedge clk);
    reqValid = 1'b0; ackStrobe = 1'b0; eoiStrobe = 1'b0;
    tprWrite = 1'b0; svrWrite = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    check("R1 pending", irqPending, 0);
    check("R1 vector", ackVector, 8'hFF);
    check("R1 level", eoiLevel, 0);
    doOp(OP_REQ, 9'h040, 1'b0);
    check("R1 enable clear", irqPending, 0);
    check("R3 disabled ack vector", ackVector, 8'hFF);
    doReset();

    // table walk
    for (int i = 0; i < NROWS; i++) begin
      doOp(STIM[i][22:20], STIM[i][19:11], STIM[i][10]);
      check("R5 pending", irqPending, STIM[i][9]);
      check("R7 ack vector", ackVector, STIM[i][8:1]);
      check("R12 eoi level", eoiLevel, STIM[i][0]);
    end

    // R1 reset mid-run restores the spurious register
    doReset();
    check("R1 svr after reset", ackVector, 8'hFF);
    check("R1 pending after reset", irqPending, 0);

    // R4 word boundary, R5 equal class is not signalled
    doOp(OP_SVR, 9'h1E7, 1'b0);
    doOp(OP_REQ, 9'h01F, 1'b0);
    doOp(OP_REQ, 9'h020, 1'b1);
    check("R4 word boundary", ackVector, 8'h20);
    doOp(OP_ACK, 9'h000, 1'b0);
    check("R4 lower word next", ackVector, 8'h1F);
    check("R5 lower class masked", irqPending, 0);
    check("R12 level in service", eoiLevel, 1);
    doOp(OP_REQ, 9'h021, 1'b0);
    check("R5 equal class masked", irqPending, 0);
    doOp(OP_REQ, 9'h030, 1'b0);
    check("R5 higher class signalled", irqPending, 1);
    check("R4 top of pending", ackVector, 8'h30);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule